// File: doc/BRIEF.md
# Edge Event Capture and Interrupt Request Unit

This block watches a bank of already filtered digital input levels and records selected transitions on them. Each channel has its own event enable bit. The edge direction that counts as an event is chosen per group of four adjacent channels. Each input is first brought into the clock domain through a short synchronizer chain. A one-cycle edge pulse is then formed and latched into a sticky status bit. The host reads status bits and clears them by writing ones.

The latched, enabled status bits are combined into one interrupt request. An interrupt control register gates that request and holds an interrupt vector byte. Event capture only runs while the `enh_mode` input is high. A self-clearing bit in the interrupt control register performs a soft reset of the capture core. The soft reset clears the enables, the polarities and the status bits. It leaves the interrupt gate and the vector unchanged. Only the hardware reset clears those two.

The register port is a plain single-cycle write strobe plus an independent combinational read address. Register addresses are: 0 channel enables, 1 group polarities, 2 event status, 3 interrupt control, 4 vector. Any other address reads zero.

Top module: `evsense_irq_ctrl`

## Requirements
- R1: After hardware reset the enable, polarity, status, interrupt control and vector registers all read 0, and `irq_req` is 0.
- R2: With enable bit i set and polarity bit i/4 at 0, a low-to-high change on `din[i]` sets status bit i (address 2). The bit is readable three rising edges after the change. A high-to-low change does not set it.
- R3: With polarity bit g (address 1, bit g, covering channels 4g to 4g+3) at 1, only high-to-low changes on those channels set their status bits.
- R4: A transition on a channel whose enable bit (address 0, bit i) is 0 leaves its status bit unchanged.
- R5: While `enh_mode` is 0, no transition sets any status bit. Transitions that occurred during that time are not reported later.
- R6: Writing address 2 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R7: When a qualifying edge is detected in the same cycle as a clear of its status bit, the bit remains set.
- R8: `irq_req` is 1 exactly when interrupt control bit 0 is 1 and at least one status bit is set whose channel enable is also set.
- R9: Writing address 3 with bit 1 set clears enables, polarities and status in that cycle. Interrupt control bit 0 takes the written bit 0, and the vector is kept. Bit 1 always reads 0. Afterwards all groups detect rising edges.
- R10: Hardware reset clears interrupt control bit 0 and the vector register.
- R11: One level change produces exactly one event. A level held steady does not set a status bit again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| enh_mode | input | 1 | Enables event capture when 1 |
| din | input | NUM_CH | Debounced input levels, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NUM_CH | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NUM_CH | Read data for `rd_addr`, zero-extended |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | VEC_W | Stored interrupt vector |

## Verification
The bench targets the cycle where a fresh edge meets a write-one clear of the same bit. A design that lets the clear win would silently drop that event. It also checks that the soft reset keeps the interrupt gate and vector while returning every group to rising polarity. A design that clears too much loses the vector; one that clears too little keeps stale negative groups. Further checks cover a channel disabled after it latched an event, and transitions made while capture is off. The first must drop the interrupt while its status bit stays set. The second must not leak out as late events, which a design that only froze status updates would do.

// File: rtl/evsense_pkg.sv
package evsense_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      ADR_CHEN = 3'd0,
      ADR_GPOL = 3'd1,
      ADR_STAT = 3'd2,
      ADR_ICTL = 3'd3,
      ADR_IVEC = 3'd4
   } reg_addr_e;

   localparam int ICTL_GATE_BIT = 0;
   localparam int ICTL_SRST_BIT = 1;
endpackage

// File: rtl/evsense_sync.sv
module evsense_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 1 && STAGES <= 4) else $error("STAGES out of range");

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/evsense_edge.sv
module evsense_edge #(
   parameter int NUM_CH = 32,
   parameter int GRP_W  = 4,
   localparam int NUM_GRP = NUM_CH / GRP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [NUM_CH-1:0]  lvl,
   input  logic [NUM_CH-1:0]  en,
   input  logic [NUM_GRP-1:0] pol_neg,
   output logic [NUM_CH-1:0]  ev
);
   initial assert (NUM_CH % GRP_W == 0) else $error("NUM_CH must be a multiple of GRP_W");

   logic [NUM_CH-1:0] prev;
   logic [NUM_CH-1:0] rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         localparam int LO = g * GRP_W;
         logic [GRP_W-1:0] pick;
         assign pick = pol_neg[g] ? fall[LO +: GRP_W] : rise[LO +: GRP_W];
         assign ev[LO +: GRP_W] = pick & en[LO +: GRP_W] & {GRP_W{active}};
      end
   endgenerate

   // a single transition yields a one-cycle pulse only
   p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> ((ev & $past(ev)) == '0));
endmodule

// File: rtl/evsense_status.sv
module evsense_status #(
   parameter int NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic [NUM_CH-1:0] ev,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] st
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= '0;
      else if (srst) st <= '0;
      else           st <= (st & ~clr) | ev;
   end

   p_set_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ev) && !srst) |=> ((st & $past(ev)) == $past(ev)));

   p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (st == '0));

   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((st & ~$past(st) & ~$past(ev)) == '0));
endmodule

// File: rtl/evsense_irq_ctrl.sv
module evsense_irq_ctrl
   import evsense_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int GRP_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   localparam int NUM_GRP    = NUM_CH / GRP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enh_mode,
   input  logic [NUM_CH-1:0] din,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [NUM_CH-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [NUM_CH-1:0] rd_data,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector
);
   initial assert (VEC_W <= NUM_CH && NUM_GRP <= NUM_CH && NUM_CH >= 2)
      else $error("register widths exceed data width");

   logic [NUM_CH-1:0]  en_q;
   logic [NUM_GRP-1:0] pol_q;
   logic               gate_q;
   logic [VEC_W-1:0]   vec_q;
   logic [NUM_CH-1:0]  lvl_s, ev, stat, clr;
   logic               wr_chen, wr_gpol, wr_stat, wr_ictl, wr_ivec, srst;

   assign wr_chen = wr_en && (wr_addr == ADR_CHEN);
   assign wr_gpol = wr_en && (wr_addr == ADR_GPOL);
   assign wr_stat = wr_en && (wr_addr == ADR_STAT);
   assign wr_ictl = wr_en && (wr_addr == ADR_ICTL);
   assign wr_ivec = wr_en && (wr_addr == ADR_IVEC);
   assign srst    = wr_ictl && wr_data[ICTL_SRST_BIT];
   assign clr     = wr_stat ? wr_data : '0;

   // core configuration: cleared by either reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= '0;
      end else if (srst) begin
         en_q  <= '0;
         pol_q <= '0;
      end else begin
         if (wr_chen) en_q  <= wr_data;
         if (wr_gpol) pol_q <= wr_data[NUM_GRP-1:0];
      end
   end

   // interrupt registers: only the hardware reset clears them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         if (wr_ictl) gate_q <= wr_data[ICTL_GATE_BIT];
         if (wr_ivec) vec_q  <= wr_data[VEC_W-1:0];
      end
   end

   evsense_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(din), .q(lvl_s)
   );

   evsense_edge #(.NUM_CH(NUM_CH), .GRP_W(GRP_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .active(enh_mode), .lvl(lvl_s),
      .en(en_q), .pol_neg(pol_q), .ev(ev)
   );

   evsense_status #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ev(ev), .clr(clr), .st(stat)
   );

   assign irq_req    = gate_q && |(stat & en_q);
   assign irq_vector = vec_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADR_CHEN: rd_data = en_q;
         ADR_GPOL: rd_data[NUM_GRP-1:0] = pol_q;
         ADR_STAT: rd_data = stat;
         ADR_ICTL: rd_data[ICTL_GATE_BIT] = gate_q;
         ADR_IVEC: rd_data[VEC_W-1:0] = vec_q;
         default:  rd_data = '0;
      endcase
   end

   p_ictl_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (gate_q == $past(wr_data[ICTL_GATE_BIT]) && vec_q == $past(vec_q)));

   p_cfg_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (en_q == '0 && pol_q == '0));

   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (stat != '0));

   p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!enh_mode && $past(rst_n)) |=> ((stat & ~$past(stat)) == '0));
endmodule

// File: tb/evsense_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evsense_irq_ctrl_tb_top;
   localparam int NCH = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            enh_mode = 1'b0;
   logic [NCH-1:0]  din = '0;
   logic            wr_en = 1'b0;
   logic [2:0]      wr_addr = '0;
   logic [NCH-1:0]  wr_data = '0;
   logic [2:0]      rd_addr = '0;
   logic [NCH-1:0]  rd_data;
   logic            irq_req;
   logic [7:0]      irq_vector;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [2:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   evsense_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .din(din),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_req(irq_req), .irq_vector(irq_vector)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            rd_addr = it.addr;
            #1;
            act = it.is_irq ? {31'd0, irq_req} : rd_data;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      it.is_irq = 1'b1; it.addr = 3'd0; it.exp = {31'd0, e}; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic set_din(input logic [31:0] v);
      @(negedge clk);
      din = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      hw_reset();
      // R1 reset state
      expect_reg(3'd0, 32'h0, "R1 enable reset");
      expect_reg(3'd1, 32'h0, "R1 polarity reset");
      expect_reg(3'd2, 32'h0, "R1 status reset");
      expect_reg(3'd3, 32'h0, "R1 ictl reset");
      expect_reg(3'd4, 32'h0, "R1 vector reset");
      expect_irq(1'b0, "R1 irq reset");

      enh_mode = 1'b1;
      wr(3'd0, 32'h0000_10FF);
      wr(3'd1, 32'h0000_0002);
      expect_reg(3'd0, 32'h0000_10FF, "R2 enable readback");
      expect_reg(3'd1, 32'h0000_0002, "R3 polarity readback");

      // R2 rising on ch0, R3 ch4 negative ignores rise, R4 ch20 disabled
      set_din(32'h0010_0011);
      expect_reg(3'd2, 32'h0000_0001, "R2 R3 R4 rising pattern");
      set_din(32'h0010_0000);
      expect_reg(3'd2, 32'h0000_0011, "R3 falling on negative group");

      // R6 write-one clear
      wr(3'd2, 32'h0000_0001);
      expect_reg(3'd2, 32'h0000_0010, "R6 clear selected bit");
      wr(3'd2, 32'h0000_0000);
      expect_reg(3'd2, 32'h0000_0010, "R6 zero write keeps bits");
      wr(3'd2, 32'h0000_0010);
      expect_reg(3'd2, 32'h0000_0000, "R6 clear remaining");

      // R11 held level does not retrigger
      repeat (10) @(negedge clk);
      expect_reg(3'd2, 32'h0000_0000, "R11 no retrigger on held level");

      // R8 interrupt gating
      wr(3'd3, 32'h0000_0001);
      expect_irq(1'b0, "R8 gate on no status");
      set_din(32'h0010_0002);
      expect_reg(3'd2, 32'h0000_0002, "R8 status ch1");
      expect_irq(1'b1, "R8 irq asserted");
      wr(3'd0, 32'h0000_10FD);
      expect_irq(1'b0, "R8 disabled channel masks irq");
      expect_reg(3'd2, 32'h0000_0002, "R4 status kept when disabled");
      wr(3'd0, 32'h0000_10FF);
      expect_irq(1'b1, "R8 re-enabled irq");
      wr(3'd3, 32'h0000_0000);
      expect_irq(1'b0, "R8 gate off");

      // R5 capture off
      enh_mode = 1'b0;
      set_din(32'h0010_0006);
      expect_reg(3'd2, 32'h0000_0002, "R5 no capture when off");
      enh_mode = 1'b1;
      repeat (5) @(negedge clk);
      expect_reg(3'd2, 32'h0000_0002, "R5 no late event");
      wr(3'd2, 32'h0000_0002);

      // R7 edge meets clear
      set_din(32'h0010_0007);
      expect_reg(3'd2, 32'h0000_0001, "R7 setup ch0");
      set_din(32'h0010_0006);
      @(negedge clk);
      din = 32'h0010_0007;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h0000_0001;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      expect_reg(3'd2, 32'h0000_0001, "R7 edge wins over clear");
      wr(3'd2, 32'h0000_0001);
      expect_reg(3'd2, 32'h0000_0000, "R7 plain clear");

      // R9 soft reset
      wr(3'd4, 32'h0000_00A5);
      wr(3'd3, 32'h0000_0001);
      set_din(32'h0010_000F);
      expect_reg(3'd2, 32'h0000_0008, "R9 setup ch3");
      expect_irq(1'b1, "R9 irq before soft reset");
      wr(3'd3, 32'h0000_0003);
      expect_reg(3'd0, 32'h0, "R9 enables cleared");
      expect_reg(3'd1, 32'h0, "R9 polarity cleared");
      expect_reg(3'd2, 32'h0, "R9 status cleared");
      expect_reg(3'd3, 32'h0000_0001, "R9 gate kept, srst reads 0");
      expect_reg(3'd4, 32'h0000_00A5, "R9 vector kept");
      expect_irq(1'b0, "R9 irq after soft reset");
      set_din(32'h0010_0007);
      expect_reg(3'd2, 32'h0, "R9 R4 disabled after soft reset");
      wr(3'd0, 32'h0000_0010);
      set_din(32'h0010_0017);
      expect_reg(3'd2, 32'h0000_0010, "R9 group back to rising");
      expect_irq(1'b1, "R9 irq with kept gate");

      // R10 hardware reset
      hw_reset();
      expect_reg(3'd3, 32'h0, "R10 gate cleared");
      expect_reg(3'd4, 32'h0, "R10 vector cleared");
      expect_irq(1'b0, "R10 irq cleared");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule